// File: doc/BRIEF.md
# Predicated Vector Carry-Chain Adder

This block adds or subtracts two 128-bit vectors split into four 32-bit lanes, with the carry out of one lane feeding the carry in of the next. The whole vector therefore acts as a single wide add-with-carry or subtract-with-carry. A 16-bit predicate, one bit per byte, decides two things: which destination bytes take the new result, and which lanes are allowed to update the running carry. The block also returns a new 4-bit condition-flag vector. Its C bit records the final carry.

The caller supplies the following inputs:
- the old destination value;
- the two operands;
- an add/subtract select;
- a select that forces a fixed starting carry;
- an indication that the first beat of the operation is skipped;
- the current flags.

With the default parameters the results are registered once, captured on a cycle where the valid input is high.

Top module: `vcc_top`

## Requirements
- R1: With `op_sub`=0, each lane result is the low 32 bits of opn lane + opm lane + the lane's incoming carry. Lane e occupies bits [32e+31:32e].
- R2: With `op_sub`=1, opm is bitwise inverted before the addition, so a lane result is opn + ~opm + carry.
- R3: Carry moves from lane 0 upward. Lane e replaces the running carry with its own carry out only when pred_mask bit 4e is 1. Otherwise the running carry passes to lane e+1 unchanged.
- R4: Destination byte k (bits [8k+7:8k]) takes result byte k when pred_mask[k] is 1, and keeps dst_old byte k when pred_mask[k] is 0.
- R5: Flags are ordered {N,Z,C,V} in bits [3:0], so C is bit 1. When `fixed_carry`=0, the initial carry is flags_in bit 1 and the starting flags are flags_in.
- R6: When `fixed_carry`=1 and `skip_first`=0, the initial carry is 0 for add and 1 for subtract. The starting flags are {0,0,initial carry,0}.
- R7: When `fixed_carry`=1 and `skip_first`=1, the initial carry and the starting flags come from flags_in, exactly as in R5.
- R8: If pred_mask bits 0, 4, 8 and 12 are all 0, flags_out equals the starting flags.
- R9: If any of pred_mask bits 0, 4, 8, 12 is 1, flags_out has N, Z and V at 0 and C equal to the final running carry.
- R10: The reset values, held through an active-low synchronous reset, are out_valid=0, dst_new=0 and flags_out=0. Results appear one clock after a cycle with in_valid=1, out_valid mirrors in_valid delayed by one clock, and the outputs hold while in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Capture the inputs this cycle |
| op_sub | input | 1 | 0 = add with carry, 1 = subtract with carry |
| fixed_carry | input | 1 | 1 = use the fixed starting carry variant |
| skip_first | input | 1 | First beat of the operation is skipped |
| pred_mask | input | 16 | Per-byte predicate |
| dst_old | input | 128 | Previous destination value |
| opn | input | 128 | First operand |
| opm | input | 128 | Second operand |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| out_valid | output | 1 | Result registers updated last cycle |
| dst_new | output | 128 | Merged destination |
| flags_out | output | 4 | New flags {N,Z,C,V} |

## Verification
The hardest situation to reach from the ports is a carry that skips over a lane. This needs a lane whose lowest byte is masked off, standing between a lane that produces a carry and a lane that consumes it, while the destination still shows only the unmasked bytes. Random operands rarely line up such a case. Directed vectors therefore set opn to all ones and opm to zero, so that any carry entering a lane must ripple through all 32 bits of it. Sweeps then cover every combination of operation, fixed-carry and skip-first-beat with all 16 flag inputs and a set of mask patterns that switch individual lane-enable bits.

// File: rtl/vcc_pkg.sv
// Package: shared flag layout and types for the carry-chain adder.
// Assumes flags are always carried as {N,Z,C,V}, most significant first.
package vcc_pkg;
    localparam int FLAG_W = 4;
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;
    typedef logic [FLAG_W-1:0] nzcv_t;
endpackage

// File: rtl/vcc_carry_seed.sv
// Module: picks the starting flags and the initial carry of the chain.
// Assumes the fixed variant carries 0 for add and 1 for subtract, and
// falls back to the live flags when the first beat is skipped.
module vcc_carry_seed
    import vcc_pkg::*;
(
    input  logic  op_sub,
    input  logic  fixed_carry,
    input  logic  skip_first,
    input  nzcv_t flags_in,
    output nzcv_t base_flags,
    output logic  seed_carry
);
    logic use_fixed;

    // Purpose: decide whether the constant starting carry applies.
    always_comb begin
        use_fixed = fixed_carry & ~skip_first;
    end

    // Purpose: build the starting flags and pull out the seed carry.
    always_comb begin
        if (use_fixed) begin
            base_flags         = '0;
            base_flags[FLAG_C] = op_sub;
        end else begin
            base_flags = flags_in;
        end
        seed_carry = base_flags[FLAG_C];
    end
endmodule

// File: rtl/vcc_lane.sv
// Module: one lane of the chained adder with byte-wise destination merge.
// Assumes bmask[0] is the lane's lowest byte and gates the carry update.
module vcc_lane #(
    parameter int LANE_W = 32
) (
    input  logic [LANE_W-1:0]   a,
    input  logic [LANE_W-1:0]   b,
    input  logic [LANE_W-1:0]   old,
    input  logic                sub,
    input  logic                cin,
    input  logic [LANE_W/8-1:0] bmask,
    output logic [LANE_W-1:0]   merged,
    output logic                cout_run
);
    localparam int BYTES = LANE_W / 8;

    logic [LANE_W-1:0] b_eff;
    logic [LANE_W:0]   sum;

    // Purpose: invert the second operand for subtract, then add with carry.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = {1'b0, a} + {1'b0, b_eff} + {{LANE_W{1'b0}}, cin};
    end

    // Purpose: pass the lane carry on only when the lane's low byte is enabled.
    always_comb begin
        cout_run = bmask[0] ? sum[LANE_W] : cin;
    end

    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        // Purpose: keep or replace one destination byte.
        always_comb begin
            merged[8*k +: 8] = bmask[k] ? sum[8*k +: 8] : old[8*k +: 8];
        end
    end
endmodule

// File: rtl/vcc_flag_merge.sv
// Module: forms the outgoing flags from the chain result.
// Assumes any_active is high when at least one lane advanced the carry.
module vcc_flag_merge
    import vcc_pkg::*;
(
    input  nzcv_t base_flags,
    input  logic  any_active,
    input  logic  final_carry,
    output nzcv_t flags_out
);
    // Purpose: clear N/Z/V and load C when the chain ran, else keep start flags.
    always_comb begin
        if (any_active) begin
            flags_out         = '0;
            flags_out[FLAG_C] = final_carry;
        end else begin
            flags_out = base_flags;
        end
    end
endmodule

// File: rtl/vcc_top.sv
// Module: predicated vector add/subtract with carry chained across lanes.
// Assumes pred_mask carries one bit per destination byte and that lanes
// are processed from the least significant upward. REG_OUT selects an
// output register stage (1) or a purely combinational path (0).
module vcc_top
    import vcc_pkg::*;
#(
    parameter int LANES   = 4,
    parameter int LANE_W  = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int VEC_W  = LANES * LANE_W,
    localparam int BYTES  = LANE_W / 8,
    localparam int MASK_W = LANES * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              op_sub,
    input  logic              fixed_carry,
    input  logic              skip_first,
    input  logic [MASK_W-1:0] pred_mask,
    input  logic [VEC_W-1:0]  dst_old,
    input  logic [VEC_W-1:0]  opn,
    input  logic [VEC_W-1:0]  opm,
    input  logic [3:0]        flags_in,
    output logic              out_valid,
    output logic [VEC_W-1:0]  dst_new,
    output logic [3:0]        flags_out
);
    nzcv_t             base_flags;
    nzcv_t             flags_c;
    logic [LANES:0]    chain;
    logic [LANES-1:0]  lane_on;
    logic              any_active;
    logic [VEC_W-1:0]  dst_c;

    vcc_carry_seed u_seed (
        .op_sub      (op_sub),
        .fixed_carry (fixed_carry),
        .skip_first  (skip_first),
        .flags_in    (flags_in),
        .base_flags  (base_flags),
        .seed_carry  (chain[0])
    );

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        vcc_lane #(.LANE_W(LANE_W)) u_lane (
            .a        (opn[e*LANE_W +: LANE_W]),
            .b        (opm[e*LANE_W +: LANE_W]),
            .old      (dst_old[e*LANE_W +: LANE_W]),
            .sub      (op_sub),
            .cin      (chain[e]),
            .bmask    (pred_mask[e*BYTES +: BYTES]),
            .merged   (dst_c[e*LANE_W +: LANE_W]),
            .cout_run (chain[e+1])
        );
        // Purpose: note whether this lane advances the carry.
        always_comb begin
            lane_on[e] = pred_mask[e*BYTES];
        end
    end

    // Purpose: flags change only if some lane took part in the chain.
    always_comb begin
        any_active = |lane_on;
    end

    vcc_flag_merge u_flags (
        .base_flags  (base_flags),
        .any_active  (any_active),
        .final_carry (chain[LANES]),
        .flags_out   (flags_c)
    );

    if (REG_OUT) begin : g_reg
        // Purpose: output stage, loaded on valid, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_valid <= 1'b0;
                dst_new   <= '0;
                flags_out <= '0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    dst_new   <= dst_c;
                    flags_out <= flags_c;
                end
            end
        end
    end else begin : g_comb
        // Purpose: bypass the register stage.
        always_comb begin
            out_valid = in_valid;
            dst_new   = dst_c;
            flags_out = flags_c;
        end
    end
endmodule

// File: rtl/vcc_top_chk.sv
// Module: protocol and flag checks for vcc_top, attached by bind.
// Assumes the registered variant; nothing is checked when REG_OUT is 0.
module vcc_top_chk #(
    parameter int VEC_W   = 128,
    parameter int MASK_W  = 16,
    parameter int BYTES   = 4,
    parameter bit REG_OUT = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              op_sub,
    input logic              fixed_carry,
    input logic              skip_first,
    input logic [MASK_W-1:0] pred_mask,
    input logic [VEC_W-1:0]  dst_old,
    input logic [3:0]        flags_in,
    input logic              out_valid,
    input logic [VEC_W-1:0]  dst_new,
    input logic [3:0]        flags_out
);
    logic lane_any;

    // Purpose: collect the lane-enable bits of the predicate.
    always_comb begin
        lane_any = 1'b0;
        for (int e = 0; e < MASK_W / BYTES; e++) begin
            lane_any = lane_any | pred_mask[e*BYTES];
        end
    end

    if (REG_OUT) begin : g_chk
        // R10
        valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);
        // R10
        valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);
        // R10
        hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(dst_new) && $stable(flags_out)));
        // R4
        mask_off_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && pred_mask == '0) |=> dst_new == $past(dst_old));
        // R9
        nzv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && lane_any) |=> (flags_out[3] == 1'b0 && flags_out[2] == 1'b0
                                        && flags_out[0] == 1'b0));
        // R8
        flags_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !lane_any && (!fixed_carry || skip_first))
            |=> flags_out == $past(flags_in));
        // R6
        fixed_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && !lane_any && fixed_carry && !skip_first)
            |=> flags_out == {2'b00, $past(op_sub), 1'b0});
    end
endmodule

bind vcc_top vcc_top_chk #(
    .VEC_W   (VEC_W),
    .MASK_W  (MASK_W),
    .BYTES   (BYTES),
    .REG_OUT (REG_OUT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .op_sub      (op_sub),
    .fixed_carry (fixed_carry),
    .skip_first  (skip_first),
    .pred_mask   (pred_mask),
    .dst_old     (dst_old),
    .flags_in    (flags_in),
    .out_valid   (out_valid),
    .dst_new     (dst_new),
    .flags_out   (flags_out)
);

// File: tb/vcc_top_tb_top.sv
module vcc_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         op_sub = 1'b0;
    logic         fixed_carry = 1'b0;
    logic         skip_first = 1'b0;
    logic [15:0]  pred_mask = '0;
    logic [127:0] dst_old = '0;
    logic [127:0] opn = '0;
    logic [127:0] opm = '0;
    logic [3:0]   flags_in = '0;
    logic         out_valid;
    logic [127:0] dst_new;
    logic [3:0]   flags_out;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    vcc_top dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .fixed_carry(fixed_carry), .skip_first(skip_first), .pred_mask(pred_mask),
        .dst_old(dst_old), .opn(opn), .opm(opm), .flags_in(flags_in),
        .out_valid(out_valid), .dst_new(dst_new), .flags_out(flags_out)
    );

    // Behavioural model: returns {flags, destination}.
    function automatic logic [131:0] model(input logic sub, input logic fx,
                                           input logic sk, input logic [15:0] m,
                                           input logic [127:0] d, input logic [127:0] a,
                                           input logic [127:0] b, input logic [3:0] fl);
        logic [3:0]   base;
        logic         c;
        logic         any;
        logic [32:0]  s;
        logic [31:0]  bb;
        logic [127:0] r;
        base = (fx && !sk) ? {2'b00, sub, 1'b0} : fl;
        c    = base[1];
        any  = 1'b0;
        r    = d;
        for (int e = 0; e < 4; e++) begin
            bb = sub ? ~b[32*e +: 32] : b[32*e +: 32];
            s  = {1'b0, a[32*e +: 32]} + {1'b0, bb} + {32'd0, c};
            if (m[4*e]) begin
                c   = s[32];
                any = 1'b1;
            end
            for (int k = 0; k < 4; k++)
                if (m[4*e+k]) r[32*e+8*k +: 8] = s[8*k +: 8];
        end
        return {(any ? {2'b00, c, 1'b0} : base), r};
    endfunction

    task automatic chk_vec(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_flg(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive one operation, then sample a full cycle later away from the edge.
    task automatic run_op(input string dtag, input string ftag, input logic sub,
                          input logic fx, input logic sk, input logic [15:0] m,
                          input logic [127:0] d, input logic [127:0] a,
                          input logic [127:0] b, input logic [3:0] fl);
        logic [131:0] exp;
        exp = model(sub, fx, sk, m, d, a, b, fl);
        @(negedge clk);
        in_valid = 1'b1; op_sub = sub; fixed_carry = fx; skip_first = sk;
        pred_mask = m; dst_old = d; opn = a; opm = b; flags_in = fl;
        @(negedge clk);
        in_valid = 1'b0;
        chk_vec(dtag, dst_new, exp[127:0]);
        chk_flg(ftag, flags_out, exp[131:128]);
    endtask

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0]  masks [6];
        logic [127:0] hold_d;
        logic [3:0]   hold_f;
        string        dtag;
        string        ftag;
        masks[0] = 16'hFFFF; masks[1] = 16'h0000; masks[2] = 16'h1111;
        masks[3] = 16'hEEEE; masks[4] = 16'h0F0F; masks[5] = 16'h1010;

        repeat (3) @(negedge clk);
        // R10: reset state
        n_tests++;
        if (out_valid !== 1'b0 || dst_new !== '0 || flags_out !== '0) begin
            n_fail++;
            $display("FAIL R10 reset: actual %b/%h/%h expected 0/0/0", out_valid, dst_new, flags_out);
        end
        rst_n = 1'b1;

        // R3: carry ripples through all four lanes (all-ones + 0 + 1)
        run_op("R3 ripple dst", "R3 ripple flags", 1'b0, 1'b0, 1'b0, 16'hFFFF,
               rnd128(), {128{1'b1}}, '0, 4'b0010);
        chk_vec("R3 ripple zero", dst_new, '0);
        // R3: lane 1 low byte disabled, carry skips past it into lane 2
        run_op("R3 skip dst", "R3 skip flags", 1'b0, 1'b0, 1'b0, 16'hFF0F,
               rnd128(), {128{1'b1}}, '0, 4'b0010);
        // R5: incoming C seeds lane 0 (C=0 gives no carry)
        run_op("R5 seed0 dst", "R5 seed0 flags", 1'b0, 1'b0, 1'b0, 16'h000F,
               '0, {96'd0, 32'hFFFF_FFFF}, '0, 4'b1101);
        chk_flg("R5 c0 explicit", flags_out, 4'b0000);
        // R6: fixed subtract seeds carry 1; 5 - 3 leaves no borrow
        run_op("R6 fixsub dst", "R6 fixsub flags", 1'b1, 1'b1, 1'b0, 16'h000F,
               '0, {96'd0, 32'd5}, {96'd0, 32'd3}, 4'b0000);
        chk_vec("R2 5-3", {96'd0, dst_new[31:0]}, {96'd0, 32'd2});
        // R7: skipped first beat ignores fixed seed; flags_in C=0 gives 5-3-1
        run_op("R7 skip dst", "R7 skip flags", 1'b1, 1'b1, 1'b1, 16'h000F,
               '0, {96'd0, 32'd5}, {96'd0, 32'd3}, 4'b0000);
        chk_vec("R7 5-3-1", {96'd0, dst_new[31:0]}, {96'd0, 32'd1});
        // R8: all-zero mask keeps flags and destination
        run_op("R4 zero mask dst", "R8 zero mask flags", 1'b0, 1'b0, 1'b0, 16'h0000,
               rnd128(), rnd128(), rnd128(), 4'b1011);
        chk_flg("R8 explicit", flags_out, 4'b1011);

        // R10: outputs hold while in_valid stays low
        hold_d = dst_new; hold_f = flags_out;
        @(negedge clk);
        opn = rnd128(); opm = rnd128(); pred_mask = 16'hFFFF; flags_in = 4'hF;
        repeat (2) @(negedge clk);
        chk_vec("R10 hold dst", dst_new, hold_d);
        chk_flg("R10 hold flags", flags_out, hold_f);
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 valid idle: actual %b expected 0", out_valid);
        end

        // Sweep: op x fixed x skip x all flag inputs x mask patterns
        for (int v = 0; v < 8; v++) begin
            for (int f = 0; f < 16; f++) begin
                for (int mi = 0; mi < 7; mi++) begin
                    logic [15:0] m;
                    logic        sub;
                    logic        fx;
                    logic        sk;
                    sub = v[0]; fx = v[1]; sk = v[2];
                    m = (mi == 6) ? 16'($urandom) : masks[mi];
                    if (m == 16'hFFFF) dtag = sub ? "R2 sweep dst" : "R1 sweep dst";
                    else dtag = "R4 sweep dst";
                    if ((m & 16'h1111) == 0) ftag = "R8 sweep flags";
                    else if (fx && !sk) ftag = "R6 sweep flags";
                    else if (fx) ftag = "R7 sweep flags";
                    else ftag = "R9 sweep flags";
                    run_op(dtag, ftag, sub, fx, sk, m, rnd128(), rnd128(),
                           (mi == 2) ? ~rnd128() : rnd128(), 4'(f));
                end
            end
        end

        // R10: reset clears a loaded result
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || dst_new !== '0 || flags_out !== '0) begin
            n_fail++;
            $display("FAIL R10 re-reset: actual %b/%h/%h expected 0/0/0", out_valid, dst_new, flags_out);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule